// File: doc/BRIEF.md
# Addressed SPI Slave with On-the-Fly Device Select

This block is an 8-bit serial peripheral slave meant for a bus on which several identical devices share the clock, select and data lines. The three most significant bits of every byte carry a device address. The block compares them with a pattern chosen by two strap pins while the byte is still arriving. Only a device whose strap pattern matches drives its serial output for the rest of the byte; all others keep the output released.

The serial pins are oversampled by a fast system clock through synchronizers. Edges of the serial clock are detected in the system domain. The incoming byte is captured into a write register that is presented in parallel with a one-cycle strobe. A parallel read value is latched at the moment the address matches, and its low five bits are shifted out while the rest of the incoming byte is still being received. The serial clock may idle at either level.

Top module: `spi_addr_slave`

## Requirements
- R1: After reset, `miso_oe` is 0, `wr_valid` is 0 and `wr_data` is 8'h00.
- R2: While `cs_n` is high, activity on `sck` and `mosi` has no effect: `miso_oe` stays 0, no strobe occurs and `wr_data` keeps its value. `miso_oe` returns to 0 within a few clock cycles after `cs_n` rises.
- R3: A falling edge of `cs_n` clears the bit counter and shift register, so a byte started after an aborted byte is received correctly from its first bit.
- R4: `mosi` is sampled at a falling edge of `sck` and shifted in at the next rising edge, MSB first; after a full matching byte, `wr_data` holds the byte exactly (bit 7 is the first bit sent).
- R5: The address is bits 7..5 of the byte and is checked when the third bit is shifted in. Strap `strap_sel` value s selects address {1'b0, s}: 00 gives 3'b000, 01 gives 3'b001, 10 gives 3'b010 and 11 gives 3'b011. On a mismatch `miso_oe` stays 0 and `wr_data` is not updated.
- R6: After a match, `miso_oe` is 1 from the fourth falling edge of `sck` until `cs_n` rises, and `miso` presents bits 4, 3, 2, 1, 0 of `rd_data`, one per falling edge (fourth to eighth), so the master samples them at the fourth to eighth rising edges.
- R7: The `rd_data` value used is the one present when the address matched; later changes to `rd_data` during the byte do not alter the bits sent.
- R8: `wr_valid` pulses for exactly one clock cycle, and `wr_data` loads, only when all 8 bits of a matching byte have been shifted in. A byte cut short by `cs_n` rising produces no strobe and no write.
- R9: A rising edge of `sck` with no falling edge since the previous shift (such as the leading edge of a clock idling low) shifts nothing and does not advance the count.
- R10: Clock edges after the eighth bit, while `cs_n` stays low, are ignored: no second strobe and no change of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master, either idle level |
| cs_n | input | 1 | Active-low device select from the master |
| mosi | input | 1 | Serial data from the master |
| strap_sel | input | 2 | Address strap pins selecting this device's address |
| rd_data | input | 8 | Parallel value to be shifted out after a match |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| wr_data | output | 8 | Last complete byte received with a matching address |
| wr_valid | output | 1 | One-cycle strobe marking a new `wr_data` value |

## Verification
The assertions assume that each serial clock phase lasts several system clock cycles, that `mosi` is steady around each falling edge of `sck`, and that `strap_sel` changes only while `cs_n` is high. The stimulus holds every serial phase for eight system cycles, changes `mosi` only in the high phase of `sck`, and draws straps, bytes, read values, clock idle levels, aborted bytes and surplus clock pulses from a seeded generator between frames. Half of the random bytes are forced to carry the selected address so that both matched and unmatched frames are frequent.

// File: rtl/spi_addr_pkg.sv
package spi_addr_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int STRAP_W = 2;

  // Address selected by the strap pins: the straps fill the low bits,
  // the remaining upper bits are zero.
  function automatic int strap_to_addr(input int strap);
    return strap;
  endfunction

  // Read-register bit presented on the output once cnt bits are in.
  function automatic int miso_index(input int cnt, input int width);
    return width - 1 - cnt;
  endfunction

  // True when the bit count places the next output bit inside the payload.
  function automatic bit tx_window(input int cnt, input int addr_w, input int width);
    return (cnt >= addr_w) && (cnt < width);
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int             N       = 3,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL[g]}};
      else        pipe_q <= {pipe_q[STAGES-2:0], pin[g]};
    end
    assign lvl[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL[g];
      else        prev_q <= lvl[g];
    end
    assign rise[g] =  lvl[g] & ~prev_q;
    assign fall[g] = ~lvl[g] &  prev_q;
  end

endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
  import spi_addr_pkg::*;
#(
  parameter int DATA_W  = BYTE_W,
  parameter int AW      = ADDR_W,
  parameter int SW      = STRAP_W,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [SW-1:0]     strap,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] byte_next,
  output logic              addr_hit,
  output logic              hit_ev,
  output logic              byte_done_ev
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(AW - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              samp_q;
  logic              pend_q;
  logic              hit_q;
  logic              room;
  logic              sample_ev;
  logic              shift_ev;
  logic              addr_chk_ev;
  logic              addr_match;
  logic [AW-1:0]     own_addr;

  assign room        = (cnt_q < CNT_FULL);
  assign sample_ev   = sel && sck_fall && room;
  assign shift_ev    = sel && sck_rise && pend_q && room;
  assign byte_next   = {shift_q[DATA_W-2:0], samp_q};
  assign own_addr    = AW'(strap_to_addr(int'(strap)));
  assign addr_match  = (byte_next[AW-1:0] == own_addr);
  assign addr_chk_ev = shift_ev && (cnt_q == CNT_ADDR);
  assign hit_ev      = addr_chk_ev && addr_match;
  assign byte_done_ev = shift_ev && (cnt_q == CNT_LAST) && hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      samp_q  <= 1'b0;
      pend_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else if (frame_start) begin
      shift_q <= '0;
      cnt_q   <= '0;
      samp_q  <= 1'b0;
      pend_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else if (frame_end) begin
      pend_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      if (sample_ev) begin
        samp_q <= mosi_s;
        pend_q <= 1'b1;
      end
      if (shift_ev) begin
        shift_q <= byte_next;
        cnt_q   <= cnt_q + 1'b1;
        pend_q  <= 1'b0;
      end
      if (hit_ev) hit_q <= 1'b1;
    end
  end

  assign bit_cnt  = cnt_q;
  assign addr_hit = hit_q;

endmodule

// File: rtl/spi_tx_driver.sv
module spi_tx_driver
  import spi_addr_pkg::*;
#(
  parameter int DATA_W  = BYTE_W,
  parameter int AW      = ADDR_W,
  localparam int CNT_W  = $clog2(DATA_W + 1),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sel,
  input  logic              sck_fall,
  input  logic              addr_hit,
  input  logic              hit_ev,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe
);

  logic [DATA_W-1:0] rd_lat_q;
  logic              miso_q;
  logic              oe_q;
  logic [IDX_W-1:0]  tx_idx;
  logic              drive_ev;

  assign tx_idx   = IDX_W'(miso_index(int'(bit_cnt), DATA_W));
  assign drive_ev = sel && sck_fall && addr_hit &&
                    tx_window(int'(bit_cnt), AW, DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lat_q <= '0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (frame_start) begin
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (frame_end) begin
      oe_q     <= 1'b0;
    end else begin
      if (hit_ev) rd_lat_q <= rd_data;
      if (drive_ev) begin
        miso_q <= rd_lat_q[tx_idx];
        oe_q   <= 1'b1;
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;

endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
  import spi_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = BYTE_W,
  parameter int AW          = ADDR_W,
  parameter int SW          = STRAP_W,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [SW-1:0]     strap_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_valid
);

  // synchronized pins: [2] cs_n, [1] sck, [0] mosi
  logic [2:0] pin_lvl;
  logic       cs_lvl;
  logic       sck_lvl;
  logic       mosi_lvl;
  logic [1:0] ev_rise;
  logic [1:0] ev_fall;

  logic              frame_start;
  logic              frame_end;
  logic              sel;
  logic              sck_rise_ev;
  logic              sck_fall_ev;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] byte_next;
  logic              addr_hit;
  logic              hit_ev;
  logic              byte_done_ev;

  logic [DATA_W-1:0] wr_data_q;
  logic              wr_valid_q;

  spi_in_sync #(
    .N       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   ({cs_n, sck, mosi}),
    .lvl   (pin_lvl)
  );

  assign cs_lvl   = pin_lvl[2];
  assign sck_lvl  = pin_lvl[1];
  assign mosi_lvl = pin_lvl[0];

  // [1] cs_n, [0] sck
  spi_edge_det #(
    .N       (2),
    .RST_VAL (2'b11)
  ) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({cs_lvl, sck_lvl}),
    .rise  (ev_rise),
    .fall  (ev_fall)
  );

  assign frame_start = ev_fall[1];
  assign frame_end   = ev_rise[1];
  assign sck_rise_ev = ev_rise[0];
  assign sck_fall_ev = ev_fall[0];
  assign sel         = ~cs_lvl;

  spi_rx_shifter #(
    .DATA_W (DATA_W),
    .AW     (AW),
    .SW     (SW)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .frame_end    (frame_end),
    .sel          (sel),
    .sck_rise     (sck_rise_ev),
    .sck_fall     (sck_fall_ev),
    .mosi_s       (mosi_lvl),
    .strap        (strap_sel),
    .bit_cnt      (bit_cnt),
    .byte_next    (byte_next),
    .addr_hit     (addr_hit),
    .hit_ev       (hit_ev),
    .byte_done_ev (byte_done_ev)
  );

  spi_tx_driver #(
    .DATA_W (DATA_W),
    .AW     (AW)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .sel         (sel),
    .sck_fall    (sck_fall_ev),
    .addr_hit    (addr_hit),
    .hit_ev      (hit_ev),
    .bit_cnt     (bit_cnt),
    .rd_data     (rd_data),
    .miso        (miso),
    .miso_oe     (miso_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data_q  <= '0;
      wr_valid_q <= 1'b0;
    end else begin
      wr_valid_q <= byte_done_ev;
      if (byte_done_ev) wr_data_q <= byte_next;
    end
  end

  assign wr_data  = wr_data_q;
  assign wr_valid = wr_valid_q;

endmodule

// File: rtl/spi_addr_slave_chk.sv
module spi_addr_slave_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_lvl,
  input logic              frame_start,
  input logic              sck_fall_ev,
  input logic              addr_hit,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              miso,
  input logic              miso_oe,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_valid
);

  // R2
  cs_idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> !miso_oe);

  // R3
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_cnt == '0));

  // R5
  oe_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> addr_hit);

  // R6
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && !sck_fall_ev) |=> $stable(miso));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R8
  strobe_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> addr_hit);

  // R4
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data != $past(wr_data)) |-> wr_valid);

  // R10
  bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(DATA_W));

endmodule

bind spi_addr_slave spi_addr_slave_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_lvl      (cs_lvl),
  .frame_start (frame_start),
  .sck_fall_ev (sck_fall_ev),
  .addr_hit    (addr_hit),
  .bit_cnt     (bit_cnt),
  .miso        (miso),
  .miso_oe     (miso_oe),
  .wr_data     (wr_data),
  .wr_valid    (wr_valid)
);

// File: tb/test_spi_addr_slave.sv
module test_spi_addr_slave;

  localparam int HALF = 8;
  localparam int WDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b1;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic [1:0] strap_sel = 2'b00;
  logic [7:0] rd_data = 8'h00;
  logic       miso;
  logic       miso_oe;
  logic [7:0] wr_data;
  logic       wr_valid;

  int n_chk = 0;
  int n_err = 0;
  int strobe_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] exp_wr = 8'h00;

  always #2.5 clk = ~clk;

  spi_addr_slave i_spi_addr_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .strap_sel (strap_sel),
    .rd_data   (rd_data),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid)
  );

  always @(negedge clk) if (rst_n && wr_valid) strobe_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // device selected when the top three byte bits, as a number, equal the straps
  function automatic bit exp_hit(input logic [7:0] b, input logic [1:0] s);
    return (int'(b) / 32) == int'(s);
  endfunction

  // output bit expected at bit slot i (3..7) of the byte
  function automatic logic exp_out(input logic [7:0] rd, input int i);
    return rd[7 - i];
  endfunction

  task automatic run_frame(input logic [7:0] b, input logic [7:0] rd,
                           input bit idle_hi, input int nbits,
                           input bit flip, input int extra, input string tag);
    bit         hit;
    int         oe_bad;
    int         out_bad;
    int         s0;
    hit     = exp_hit(b, strap_sel);
    oe_bad  = 0;
    out_bad = 0;
    s0      = strobe_cnt;
    rd_data = rd;
    sck     = idle_hi;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    if (!idle_hi) begin
      sck = 1'b1;  // leading edge of a low-idle clock: R9
      wait_clk(HALF);
    end
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7 - i];
      wait_clk(HALF);
      if (flip && i == 3) rd_data = ~rd;  // R7
      sck = 1'b0;
      wait_clk(HALF);
      if (miso_oe !== (hit && i >= 3)) oe_bad++;
      if (hit && i >= 3 && miso !== exp_out(rd, i)) out_bad++;
      sck = 1'b1;
    end
    for (int k = 0; k < extra; k++) begin
      mosi = $urandom_range(0, 1);
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
    end
    wait_clk(HALF);
    if (!idle_hi) begin
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(8);
    check({tag, " R5/R6 oe pattern"}, oe_bad, 0);
    if (hit) check({tag, " R6/R7 miso bits"}, out_bad, 0);
    check({tag, " R2 oe released"}, miso_oe, 1'b0);
    if (hit && nbits == 8) exp_wr = b;
    check({tag, " R8/R10 strobes"}, strobe_cnt - s0, (hit && nbits == 8) ? 1 : 0);
    check({tag, " R4/R5 wr_data"}, wr_data, exp_wr);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    wait_clk(4);
    check("R1 oe at reset", miso_oe, 1'b0);
    check("R1 strobe at reset", wr_valid, 1'b0);
    check("R1 wr_data at reset", wr_data, 8'h00);
    rst_n = 1'b1;
    wait_clk(4);

    // R5: every strap value, matching byte, both clock idle levels
    for (int s = 0; s < 4; s++) begin
      strap_sel = 2'(s);
      run_frame({1'b0, 2'(s), 5'h15}, 8'hA7 ^ 8'(s), 1'b1, 8, 1'b0, 0, "R5 match hi");
      run_frame({1'b0, 2'(s), 5'h0A}, 8'h3C + 8'(s), 1'b0, 8, 1'b0, 0, "R9 match lo");
    end
    // R5: mismatches, including the upper half of the address space
    strap_sel = 2'b01;
    run_frame(8'hE5, 8'hFF, 1'b1, 8, 1'b0, 0, "R5 miss upper");
    run_frame(8'h45, 8'hFF, 1'b0, 8, 1'b0, 0, "R5 miss other");
    // R7: read value changed after the match point
    run_frame(8'h3B, 8'h96, 1'b1, 8, 1'b1, 0, "R7 flip");
    // R8 and R3: aborted bytes, then a clean byte
    run_frame(8'h2F, 8'h55, 1'b1, 3, 1'b0, 0, "R8 cut at 3");
    run_frame(8'h2F, 8'h55, 1'b1, 7, 1'b0, 0, "R8 cut at 7");
    run_frame(8'h31, 8'hC3, 1'b1, 8, 1'b0, 0, "R3 after abort");
    // R10: surplus clock pulses after the last bit
    run_frame(8'h24, 8'h81, 1'b1, 8, 1'b0, 4, "R10 extra");

    // R2: traffic while deselected
    begin
      int s0;
      int oe_seen;
      s0 = strobe_cnt;
      oe_seen = 0;
      cs_n = 1'b1;
      for (int k = 0; k < 24; k++) begin
        mosi = $urandom_range(0, 1);
        sck = ~sck;
        wait_clk(HALF);
        if (miso_oe !== 1'b0) oe_seen++;
      end
      sck = 1'b1;
      wait_clk(HALF);
      check("R2 oe while deselected", oe_seen, 0);
      check("R2 no strobe while deselected", strobe_cnt - s0, 0);
      check("R2 wr_data held while deselected", wr_data, exp_wr);
    end
    run_frame(8'h2A, 8'h5A, 1'b1, 8, 1'b0, 0, "R2 after idle traffic");

    // random frames
    for (int n = 0; n < 60; n++) begin
      logic [7:0] b;
      logic [7:0] rd;
      int         nb;
      strap_sel = 2'($urandom_range(0, 3));
      b  = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) b[7:5] = {1'b0, strap_sel};
      rd = 8'($urandom_range(0, 255));
      nb = ($urandom_range(0, 7) == 0) ? $urandom_range(1, 7) : 8;
      run_frame(b, rd, 1'($urandom_range(0, 1)), nb,
                1'($urandom_range(0, 1)),
                (nb == 8) ? $urandom_range(0, 2) : 0, "rand R4");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule